// File: doc/BRIEF.md
# Register-Programmed SPI Master Controller

A serial-flash access master driven from a small 32-bit register bus. Software first programs the frame format, the clock divider and a transfer descriptor. The descriptor holds a transfer mode plus separate write and read byte counts, each stored as count minus one. Software then writes the command register to launch the transfer. Outgoing bytes are pushed through the data register into a 16-entry transmit FIFO, and received bytes are popped from a 16-entry receive FIFO through the same register. A status word reports both FIFO levels and a busy flag.

The sequencer drives one active-low chip select and the serial clock. It supports three data modes: write-only, read-only, and write-then-read with chip select held across both phases. Every other mode value gives a data-less select pulse. When the transmit FIFO runs dry or the receive FIFO fills, the serial clock is parked at its idle level with the device still selected. Shifting resumes as soon as software catches up, so a transfer longer than the FIFO depth can be streamed.

Register map (byte offsets, bus address bits 4:2 decoded): 0x00 format, 0x04 transfer control, 0x08 command, 0x0C data, 0x10 control, 0x14 status, 0x18 timing.

Top module: `spi_mc_top`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, busy is clear and status (0x14) reads 0x0040_4000: both FIFOs empty, with zero levels.
- R2: Mode 1 in transfer-control bits 27:24 (write-only) shifts write-count+1 bytes from the transmit FIFO MSB first on MOSI. The write count sits at bits 20:12 and holds bytes minus one.
- R3: Mode 2 (read-only) captures read-count+1 bytes from MISO, MSB first, into the receive FIFO. The read count sits at bits 8:0 and holds bytes minus one.
- R4: Mode 3 (write-then-read) shifts out all write bytes, then captures all read bytes, and chip select rises only once, at the end.
- R5: Each serial-clock half period lasts timing[7:0]+1 input clocks. The idle clock level equals format bit 1 (polarity). Format bit 0 (phase) selects sampling on the trailing edge instead of the leading edge. Format bits 12:8 hold the unit length minus one.
- R6: A command write while busy is set is ignored.
- R7: Status bits: 23 TX full, 22 TX empty, 20:16 TX level, 14 RX empty, 12:8 RX level, 0 busy.
- R8: A data-register write pushes one TX entry and is dropped when the TX FIFO holds 16. A data-register read pops one RX entry, and returns zero without any state change when the RX FIFO is empty.
- R9: If the TX FIFO is empty when a write-phase byte is due, the clock stays at idle and chip select stays low until a byte is pushed.
- R10: If the RX FIFO is full when a read-phase byte is due, the clock stays at idle and chip select stays low until an entry is popped.
- R11: Control register (0x10) bit 0 aborts the transfer, bit 1 empties the RX FIFO and bit 2 empties the TX FIFO. Each bit reads back as zero once its action is done.
- R12: Chip select rises timing[7:0]+1 input clocks after the last serial-clock edge, and busy clears on the same cycle.
- R13: Any mode other than 1, 2 or 3 asserts chip select for two half periods with no clock edges and then completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the strobe |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The hardest states to reach are the two stalls, where a transfer sits half finished with the device still selected. The stimulus reaches the transmit stall by launching a two-byte write with only one byte queued. It reaches the receive stall by requesting seventeen reads and not popping until the FIFO holds sixteen. In both cases the clock pin, the select pin and the status levels are checked mid-transfer, before the missing byte is supplied or an entry is drained. An abort is applied while a transfer is parked in the transmit stall. A second command is issued while a transfer is running, and a bogus restart of that second command would leave select stuck low.

// File: rtl/spi_mc_pkg.sv
`timescale 1ns/1ps
package spi_mc_pkg;
    // transfer mode codes (transfer-control bits 27:24)
    localparam logic [3:0] MODE_WO = 4'd1;
    localparam logic [3:0] MODE_RO = 4'd2;
    localparam logic [3:0] MODE_WR = 4'd3;

    // register word indices (byte address bits 4:2)
    localparam logic [2:0] REG_FMT  = 3'd0;
    localparam logic [2:0] REG_TCTL = 3'd1;
    localparam logic [2:0] REG_CMD  = 3'd2;
    localparam logic [2:0] REG_DATA = 3'd3;
    localparam logic [2:0] REG_CTRL = 3'd4;
    localparam logic [2:0] REG_STAT = 3'd5;
    localparam logic [2:0] REG_TIME = 3'd6;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LEAD, ST_WAITB, ST_SHIFT, ST_TAIL
    } eng_st_e;

    typedef enum logic [1:0] {
        PH_WR, PH_RD, PH_NONE
    } phase_e;
endpackage

// File: rtl/spi_mc_fifo.sv
`timescale 1ns/1ps
module spi_mc_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [$clog2(DEPTH):0] count,
    output logic             full,
    output logic             empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full    = (q.cnt == CW'(DEPTH));
    assign empty   = (q.cnt == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;

    always_comb begin
        d = q;
        if (do_push) d.wp = (q.wp == AW'(DEPTH-1)) ? '0 : q.wp + 1'b1;
        if (do_pop)  d.rp = (q.rp == AW'(DEPTH-1)) ? '0 : q.rp + 1'b1;
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
        if (clr) d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wp] <= wdata;
    end

    assign rdata = mem[q.rp];
    assign count = q.cnt;
endmodule

// File: rtl/spi_mc_regs.sv
`timescale 1ns/1ps
module spi_mc_regs
    import spi_mc_pkg::*;
#(
    parameter int CNT_W = 9,
    parameter int DIV_W = 8,
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [7:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             cpol,
    output logic             cpha,
    output logic [3:0]       mode,
    output logic [CNT_W-1:0] wcnt,
    output logic [CNT_W-1:0] rcnt,
    output logic [DIV_W-1:0] div,
    output logic             start,
    output logic             core_rst,
    output logic             tx_clr,
    output logic             rx_clr,
    output logic             tx_push,
    output logic [7:0]       tx_wdata,
    output logic             rx_pop,
    input  logic             busy,
    input  logic             tx_full,
    input  logic             tx_empty,
    input  logic [LVL_W-1:0] tx_lvl,
    input  logic             rx_empty,
    input  logic [LVL_W-1:0] rx_lvl,
    input  logic [7:0]       rx_head
);
    typedef struct packed {
        logic             cpol;
        logic             cpha;
        logic [4:0]       unit;
        logic [3:0]       mode;
        logic [CNT_W-1:0] wcnt;
        logic [CNT_W-1:0] rcnt;
        logic [DIV_W-1:0] div;
        logic [2:0]       ctrl;
    } regs_st_t;

    regs_st_t q, d;
    logic       wr, rd;
    logic [2:0] idx;

    assign wr  = bus_sel && bus_we;
    assign rd  = bus_sel && !bus_we;
    assign idx = bus_addr[4:2];

    always_comb begin
        d = q;
        d.ctrl = 3'b000;                 // actions last one cycle, then clear
        if (wr) begin
            case (idx)
                REG_FMT: begin
                    d.cpha = bus_wdata[0];
                    d.cpol = bus_wdata[1];
                    d.unit = bus_wdata[12:8];
                end
                REG_TCTL: begin
                    d.mode = bus_wdata[27:24];
                    d.wcnt = bus_wdata[12 +: CNT_W];
                    d.rcnt = bus_wdata[0 +: CNT_W];
                end
                REG_CTRL: d.ctrl = bus_wdata[2:0];
                REG_TIME: d.div  = bus_wdata[DIV_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.unit <= 5'd7;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (idx)
            REG_FMT: begin
                bus_rdata[0]    = q.cpha;
                bus_rdata[1]    = q.cpol;
                bus_rdata[12:8] = q.unit;
            end
            REG_TCTL: begin
                bus_rdata[27:24]       = q.mode;
                bus_rdata[12 +: CNT_W] = q.wcnt;
                bus_rdata[0 +: CNT_W]  = q.rcnt;
            end
            REG_DATA: bus_rdata[7:0] = rx_empty ? 8'h00 : rx_head;
            REG_CTRL: bus_rdata[2:0] = q.ctrl;
            REG_STAT: begin
                bus_rdata[23]          = tx_full;
                bus_rdata[22]          = tx_empty;
                bus_rdata[16 +: LVL_W] = tx_lvl;
                bus_rdata[14]          = rx_empty;
                bus_rdata[8 +: LVL_W]  = rx_lvl;
                bus_rdata[0]           = busy;
            end
            REG_TIME: bus_rdata[DIV_W-1:0] = q.div;
            default: ;
        endcase
    end

    assign cpol     = q.cpol;
    assign cpha     = q.cpha;
    assign mode     = q.mode;
    assign wcnt     = q.wcnt;
    assign rcnt     = q.rcnt;
    assign div      = q.div;
    assign core_rst = q.ctrl[0];
    assign rx_clr   = q.ctrl[1];
    assign tx_clr   = q.ctrl[2];
    assign start    = wr && (idx == REG_CMD) && !busy;
    assign tx_push  = wr && (idx == REG_DATA);
    assign tx_wdata = bus_wdata[7:0];
    assign rx_pop   = rd && (idx == REG_DATA);
endmodule

// File: rtl/spi_mc_engine.sv
`timescale 1ns/1ps
module spi_mc_engine
    import spi_mc_pkg::*;
#(
    parameter int CNT_W = 9,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             core_rst,
    input  logic             start,
    input  logic [3:0]       mode,
    input  logic [CNT_W-1:0] wcnt,
    input  logic [CNT_W-1:0] rcnt,
    input  logic             cpol,
    input  logic             cpha,
    input  logic [DIV_W-1:0] div,
    input  logic             tx_empty,
    input  logic [7:0]       tx_head,
    output logic             tx_pop,
    input  logic             rx_full,
    output logic             rx_push,
    output logic [7:0]       rx_data,
    output logic             busy,
    output logic             sclk,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso
);
    localparam int LEFT_W = CNT_W + 1;

    typedef struct packed {
        eng_st_e           st;
        phase_e            ph;
        logic              rd_next;
        logic [LEFT_W-1:0] wr_left;
        logic [LEFT_W-1:0] rd_left;
        logic [DIV_W-1:0]  cnt;
        logic [3:0]        edges;
        logic              sclk;
        logic              mosi;
        logic [7:0]        sh;
        logic [7:0]        rsh;
    } eng_st_t;

    eng_st_t q, d;
    logic tick, lead, samp, drive;

    assign tick  = (q.cnt == div);
    assign lead  = ~q.edges[0];
    assign samp  = lead ^ cpha;
    assign drive = cpha ? lead : (!lead && (q.edges != 4'd15));

    always_comb begin
        d       = q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st      = ST_LEAD;
                    d.cnt     = '0;
                    d.sclk    = 1'b0;
                    d.rd_next = 1'b0;
                    d.wr_left = {1'b0, wcnt} + 1'b1;
                    d.rd_left = {1'b0, rcnt} + 1'b1;
                    case (mode)
                        MODE_WO: d.ph = PH_WR;
                        MODE_RO: d.ph = PH_RD;
                        MODE_WR: begin
                            d.ph      = PH_WR;
                            d.rd_next = 1'b1;
                        end
                        default: d.ph = PH_NONE;
                    endcase
                end
            end
            ST_LEAD: begin
                if (tick) d.st  = ST_WAITB;
                else      d.cnt = q.cnt + 1'b1;
            end
            ST_WAITB: begin
                d.cnt   = '0;
                d.edges = '0;
                case (q.ph)
                    PH_WR: begin
                        if (!tx_empty) begin
                            tx_pop = 1'b1;
                            d.st   = ST_SHIFT;
                            if (!cpha) begin
                                d.mosi = tx_head[7];
                                d.sh   = {tx_head[6:0], 1'b0};
                            end else begin
                                d.sh   = tx_head;
                            end
                        end
                    end
                    PH_RD: begin
                        if (!rx_full) begin
                            d.st = ST_SHIFT;
                            d.sh = 8'h00;
                            if (!cpha) d.mosi = 1'b0;
                        end
                    end
                    default: d.st = ST_TAIL;
                endcase
            end
            ST_SHIFT: begin
                if (!tick) begin
                    d.cnt = q.cnt + 1'b1;
                end else begin
                    d.cnt   = '0;
                    d.sclk  = ~q.sclk;
                    d.edges = q.edges + 1'b1;
                    if (samp)  d.rsh = {q.rsh[6:0], miso};
                    if (drive) begin
                        d.mosi = q.sh[7];
                        d.sh   = {q.sh[6:0], 1'b0};
                    end
                    if (q.edges == 4'd15) begin
                        d.st = ST_WAITB;
                        if (q.ph == PH_WR) begin
                            d.wr_left = q.wr_left - 1'b1;
                            if (q.wr_left == LEFT_W'(1)) begin
                                if (q.rd_next) begin
                                    d.ph = PH_RD;
                                end else begin
                                    d.ph = PH_NONE;
                                    d.st = ST_TAIL;
                                end
                            end
                        end else begin
                            rx_push   = 1'b1;
                            d.rd_left = q.rd_left - 1'b1;
                            if (q.rd_left == LEFT_W'(1)) begin
                                d.ph = PH_NONE;
                                d.st = ST_TAIL;
                            end
                        end
                    end
                end
            end
            ST_TAIL: begin
                if (tick) d.st  = ST_IDLE;
                else      d.cnt = q.cnt + 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
        if (core_rst) begin
            d.st   = ST_IDLE;
            d.ph   = PH_NONE;
            d.sclk = 1'b0;
            d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
            q.ph <= PH_NONE;
        end else begin
            q <= d;
        end
    end

    assign rx_data = d.rsh;
    assign busy    = (q.st != ST_IDLE);
    assign cs_n    = (q.st == ST_IDLE);
    assign sclk    = q.sclk ^ cpol;
    assign mosi    = q.mosi;
endmodule

// File: rtl/spi_mc_top.sv
`timescale 1ns/1ps
module spi_mc_top #(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = 9,
    parameter int DIV_W      = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        spi_sclk,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;

    logic             cpol, cpha, start, core_rst, tx_clr, rx_clr;
    logic             tx_push, rx_pop, tx_pop, rx_push, busy;
    logic [3:0]       mode;
    logic [CNT_W-1:0] wcnt, rcnt;
    logic [DIV_W-1:0] div;
    logic [7:0]       tx_wdata, tx_head, rx_wdata, rx_head;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic [LVL_W-1:0] tx_lvl, rx_lvl;

    spi_mc_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W), .LVL_W(LVL_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpol(cpol), .cpha(cpha), .mode(mode), .wcnt(wcnt), .rcnt(rcnt), .div(div),
        .start(start), .core_rst(core_rst), .tx_clr(tx_clr), .rx_clr(rx_clr),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .rx_pop(rx_pop),
        .busy(busy), .tx_full(tx_full), .tx_empty(tx_empty), .tx_lvl(tx_lvl),
        .rx_empty(rx_empty), .rx_lvl(rx_lvl), .rx_head(rx_head)
    );

    spi_mc_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txf (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .push(tx_push), .wdata(tx_wdata), .pop(tx_pop), .rdata(tx_head),
        .count(tx_lvl), .full(tx_full), .empty(tx_empty)
    );

    spi_mc_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxf (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push(rx_push), .wdata(rx_wdata), .pop(rx_pop), .rdata(rx_head),
        .count(rx_lvl), .full(rx_full), .empty(rx_empty)
    );

    spi_mc_engine #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .core_rst(core_rst), .start(start),
        .mode(mode), .wcnt(wcnt), .rcnt(rcnt), .cpol(cpol), .cpha(cpha), .div(div),
        .tx_empty(tx_empty), .tx_head(tx_head), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_wdata),
        .busy(busy), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso)
    );
endmodule

// File: rtl/spi_mc_chk.sv
`timescale 1ns/1ps
module spi_mc_chk #(
    parameter int LVL_W = 5,
    parameter int DEPTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             cs_n,
    input logic             sclk,
    input logic             cpol,
    input logic             cmd_wr,
    input logic             core_rst,
    input logic             ctrl_wr,
    input logic [2:0]       ctrl_bits,
    input logic [LVL_W-1:0] tx_lvl,
    input logic [LVL_W-1:0] rx_lvl
);
    AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (sclk == cpol)); // R5
    AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        tx_lvl <= LVL_W'(DEPTH)); // R8
    AST_RX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rx_lvl <= LVL_W'(DEPTH)); // R10
    AST_START_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_wr)); // R2
    AST_CTRL_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_bits != 3'b000) && !ctrl_wr) |=> (ctrl_bits == 3'b000)); // R11
    AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |=> !busy); // R11
endmodule

bind spi_mc_top spi_mc_chk #(.LVL_W(LVL_W), .DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .cs_n(spi_cs_n), .sclk(spi_sclk),
    .cpol(cpol),
    .cmd_wr(bus_sel && bus_we && (bus_addr[4:2] == 3'd2)),
    .core_rst(core_rst),
    .ctrl_wr(bus_sel && bus_we && (bus_addr[4:2] == 3'd4)),
    .ctrl_bits({tx_clr, rx_clr, core_rst}),
    .tx_lvl(tx_lvl), .rx_lvl(rx_lvl)
);

// File: tb/spi_mc_top_test.sv
`timescale 1ns/1ps
module spi_mc_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;

    int errs = 0, checks = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    spi_mc_top uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // ---------------- device model ----------------
    int         sb = 0;
    int         cs_rises = 0;
    time        t_r1, t_r2, t_last, t_csr;
    logic [7:0] sl_tx  [0:39];
    logic [7:0] mo_cap [0:39];

    always @(posedge spi_sclk) if (!spi_cs_n) begin
        if (sb == 0) t_r1 = $time;
        if (sb == 1) t_r2 = $time;
        mo_cap[sb/8][7-(sb%8)] = spi_mosi;
        sb = sb + 1;
    end
    always @(spi_sclk) if (!spi_cs_n) t_last = $time;
    always @(posedge spi_cs_n) begin
        t_csr = $time;
        cs_rises = cs_rises + 1;
    end
    assign spi_miso = spi_cs_n ? 1'b0 : sl_tx[(sb/8) % 40][7-(sb%8)];

    // ---------------- helpers ----------------
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic brd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int n = 0; n < 4000; n++) begin
            brd(8'h14, s);
            if (!s[0]) break;
        end
    endtask

    function automatic logic [7:0] txb(input int k, input int i);
        return 8'(8'h5A + k*37 + i*3);
    endfunction

    // ---------------- vector table ----------------
    typedef struct packed {
        logic [3:0] mode;
        logic [4:0] nw;
        logic [4:0] nr;
        logic [7:0] div;
        logic       cpol;
        logic       cpha;
        logic [7:0] exp_bits;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{4'd1, 5'd3,  5'd1, 8'd0, 1'b0, 1'b0, 8'd24},
        '{4'd2, 5'd1,  5'd4, 8'd1, 1'b0, 1'b0, 8'd32},
        '{4'd3, 5'd2,  5'd3, 8'd2, 1'b0, 1'b0, 8'd40},
        '{4'd1, 5'd16, 5'd1, 8'd0, 1'b0, 1'b0, 8'd128},
        '{4'd1, 5'd2,  5'd1, 8'd1, 1'b1, 1'b1, 8'd16},
        '{4'd3, 5'd1,  5'd1, 8'd3, 1'b0, 1'b0, 8'd16}
    };

    initial begin
        #(8*190000);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        string       req;
        for (int k = 0; k < 40; k++) sl_tx[k] = 8'hC3 ^ 8'(k*29);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        brd(8'h14, r);
        check("R1 status", r, 32'h0040_4000);
        check("R1 cs_n", {31'b0, spi_cs_n}, 32'd1);
        check("R1 sclk", {31'b0, spi_sclk}, 32'd0);
        brd(8'h0C, r);
        check("R8 empty read", r, 32'd0);

        // table of transfers: R2 R3 R4 R5 R12
        for (int i = 0; i < NV; i++) begin
            vec_t v = VECS[i];
            int   base;
            req = (v.mode == 4'd1) ? "R2" : (v.mode == 4'd2) ? "R3" : "R4";
            for (int k = 0; k < 40; k++) sl_tx[k] = 8'hC3 ^ 8'(k*29 + i);
            bwr(8'h00, {19'b0, 5'd7, 6'b0, v.cpol, v.cpha});
            bwr(8'h18, {24'b0, v.div});
            if (v.mode != 4'd2)
                for (int k = 0; k < v.nw; k++) bwr(8'h0C, {24'b0, txb(k, i)});
            bwr(8'h04, {4'b0, v.mode, 3'b0, 9'(v.nw - 1), 3'b0, 9'(v.nr - 1)});
            sb = 0; cs_rises = 0;
            bwr(8'h08, 32'd1);
            wait_idle();
            check({req, " bit count"}, sb, {24'b0, v.exp_bits});
            check({req, " single select"}, cs_rises, 32'd1);
            if (v.mode != 4'd2)
                for (int k = 0; k < v.nw; k++)
                    check({req, " mosi byte"}, {24'b0, mo_cap[k]}, {24'b0, txb(k, i)});
            base = (v.mode == 4'd3) ? int'(v.nw) : 0;
            if (v.mode != 4'd1)
                for (int k = 0; k < v.nr; k++) begin
                    brd(8'h0C, r);
                    check({req, " rx byte"}, r, {24'b0, sl_tx[base + k]});
                end
            check("R5 half period", 32'(t_r2 - t_r1), 32'(16 * (v.div + 1)));
            check("R12 tail", 32'(t_csr - t_last), 32'(8 * (v.div + 1)));
            check("R7 status idle", r & 32'h0, 32'h0);
            brd(8'h14, r);
            check("R7 status idle", r, 32'h0040_4000);
        end
        bwr(8'h00, 32'h0000_0700);
        check("R5 idle low", {31'b0, spi_sclk}, 32'd0);

        // R8 overflow drop, R11 TX clear
        for (int k = 0; k < 17; k++) bwr(8'h0C, k);
        brd(8'h14, r);
        check("R8 full level", r, 32'h0090_4000);
        bwr(8'h10, 32'd4);
        brd(8'h10, r);
        check("R11 self clear", r, 32'd0);
        brd(8'h14, r);
        check("R11 tx cleared", r, 32'h0040_4000);

        // R6 command while busy
        bwr(8'h18, 32'd3);
        bwr(8'h0C, 32'h11); bwr(8'h0C, 32'h22);
        bwr(8'h04, {4'b0, 4'd1, 3'b0, 9'd1, 12'b0});
        sb = 0;
        bwr(8'h08, 32'd1);
        repeat (20) @(negedge clk);
        bwr(8'h08, 32'd1);
        wait_idle();
        repeat (100) @(negedge clk);
        check("R6 no restart cs", {31'b0, spi_cs_n}, 32'd1);
        check("R6 bits", sb, 32'd16);

        // R9 TX stall
        bwr(8'h18, 32'd0);
        bwr(8'h0C, 32'h3C);
        bwr(8'h04, {4'b0, 4'd1, 3'b0, 9'd1, 12'b0});
        sb = 0;
        bwr(8'h08, 32'd1);
        repeat (200) @(negedge clk);
        brd(8'h14, r);
        check("R9 busy held", {31'b0, r[0]}, 32'd1);
        check("R9 cs low", {31'b0, spi_cs_n}, 32'd0);
        check("R9 sclk parked", {31'b0, spi_sclk}, 32'd0);
        check("R9 bits so far", sb, 32'd8);
        bwr(8'h0C, 32'h96);
        wait_idle();
        check("R9 bits", sb, 32'd16);
        check("R9 resumed byte", {24'b0, mo_cap[1]}, 32'h96);

        // R10 RX stall
        for (int k = 0; k < 40; k++) sl_tx[k] = 8'h0F ^ 8'(k*13);
        bwr(8'h04, {4'b0, 4'd2, 3'b0, 9'd0, 3'b0, 9'd16});
        sb = 0;
        bwr(8'h08, 32'd1);
        repeat (600) @(negedge clk);
        brd(8'h14, r);
        check("R10 stalled status", r, 32'h0040_1001);
        check("R10 cs low", {31'b0, spi_cs_n}, 32'd0);
        check("R10 bits so far", sb, 32'd128);
        for (int k = 0; k < 16; k++) begin
            brd(8'h0C, r);
            check("R10 rx byte", r, {24'b0, sl_tx[k]});
        end
        wait_idle();
        brd(8'h14, r);
        check("R10 last level", r, 32'h0040_0100);
        bwr(8'h10, 32'd2);
        brd(8'h14, r);
        check("R11 rx cleared", r, 32'h0040_4000);
        brd(8'h0C, r);
        check("R8 empty after clear", r, 32'd0);

        // R11 abort
        bwr(8'h0C, 32'h77);
        bwr(8'h04, {4'b0, 4'd1, 3'b0, 9'd3, 12'b0});
        bwr(8'h08, 32'd1);
        repeat (100) @(negedge clk);
        check("R11 stalled before abort", {31'b0, spi_cs_n}, 32'd0);
        bwr(8'h10, 32'd1);
        repeat (2) @(negedge clk);
        check("R11 abort cs", {31'b0, spi_cs_n}, 32'd1);
        brd(8'h14, r);
        check("R11 abort status", r, 32'h0040_4000);

        // R13 no-data mode
        bwr(8'h04, {4'b0, 4'd7, 24'b0});
        sb = 0; cs_rises = 0;
        bwr(8'h08, 32'd1);
        wait_idle();
        check("R13 no edges", sb, 32'd0);
        check("R13 one select", cs_rises, 32'd1);
        check("R13 cs", {31'b0, spi_cs_n}, 32'd1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule